// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block sits beside a CAN protocol engine and turns its one-cycle event pulses into interrupt requests. Per message object it latches receive-complete, transmit-complete and error events. For the node as a whole it latches form, bit and stuff errors, a receive-buffer-full event and a timer-overrun event. Every flag is sticky. Software clears a flag by writing a one to its bit through a small register port.

Two interrupt lines leave the block. The CAN line combines the enabled general-error flags, the buffer-full flag and the per-object pending bits, all gated by a global enable. The timer line has its own enable and does not depend on the global enable. The block also routes errors. An error tagged with an owning message object is recorded only in that object's status, and never in the general error flags. An untagged form error seen while the node transmits also produces a bit-error flag one cycle later. As a result, one fault gives two successive interrupt causes.

Register map: address 0 holds the enables, address 1 the general flags, address 2 the per-object enables, address 3 the pending vector (read-only), and address 4+k the status of object k.

Top module: `can_irq_agg`

## Requirements
- R1: After reset all enables, general flags, object status bits, object enables and all three outputs are zero.
- R2: A pulse on an event input sets its flag at the next clock edge, and the flag holds until software clears it. Software clears a flag by writing a one to its bit. General flags live at address 1: bit0 form, bit1 bit, bit2 stuff, bit3 buffer full, bit4 timer overrun. Object k status lives at address 4+k: bit0 receive, bit1 transmit, bit2 error. Writing zero leaves a flag unchanged.
- R3: When an event and a software clear of the same flag fall in the same cycle, the flag stays set.
- R4: `can_irq` is asserted for general errors only when the global enable (address 0 bit0) and the error enable (address 0 bit1) are both set and at least one of the form, bit or stuff flags is set.
- R5: `can_irq` is asserted for buffer full only when the global enable and the buffer-full enable (address 0 bit2) are both set and the buffer-full flag is set.
- R6: `tmr_irq` equals timer-overrun enable (address 0 bit3) AND the timer flag, independent of the global enable. The timer flag never drives `can_irq`.
- R7: Pending bit k is set when the global enable and object enable k (address 2 bit k) are both set and at least one status flag of object k is set whose type enable is also set. The type enables are at address 0: bit4 receive, bit5 transmit, bit6 error. The bit stays set until every such enabled flag is cleared. Address 3 reads the current pending vector.
- R8: An error pulse with a nonzero `err_owner` sets the error flag of each owning object, and sets none of the form, bit or stuff general flags.
- R9: An unowned form error while `tx_active` is high sets the form flag at the next edge and the bit-error flag one edge later.
- R10: `can_irq`, `tmr_irq` and `obj_pend` are registered. Each reflects the flags and enables one clock edge after they change.
- R11: A set pending bit alone is enough to assert `can_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx | input | NOBJ | Receive-complete pulse per object |
| ev_tx | input | NOBJ | Transmit-complete pulse per object |
| ev_form_err | input | 1 | Form error pulse |
| ev_bit_err | input | 1 | Bit error pulse |
| ev_stuff_err | input | 1 | Stuff error pulse |
| err_owner | input | NOBJ | Objects the current error belongs to; zero means general |
| tx_active | input | 1 | Node is transmitting |
| ev_buf_full | input | 1 | Receive buffer full pulse |
| ev_tmr_ovf | input | 1 | Timer overrun pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, combinational |
| can_irq | output | 1 | CAN interrupt request |
| tmr_irq | output | 1 | Timer-overrun interrupt request |
| obj_pend | output | NOBJ | Registered per-object pending vector |

## Verification
The bench uses the default of four message objects. With that value the address map fills the 3-bit address space exactly, so random reads and writes reach every register, including each object's status word. Four objects are also enough for multi-owner error tags and for several objects pending at the same time. The register word is seven bits wide, so every enable bit and flag bit can be hit by random write data.

// File: rtl/can_irq_agg.sv
module can_irq_agg #(
  parameter int NOBJ = 4,
  localparam int AW = $clog2(NOBJ + 4),
  localparam int DW = (NOBJ > 7) ? NOBJ : 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOBJ-1:0] ev_rx,
  input  logic [NOBJ-1:0] ev_tx,
  input  logic            ev_form_err,
  input  logic            ev_bit_err,
  input  logic            ev_stuff_err,
  input  logic [NOBJ-1:0] err_owner,
  input  logic            tx_active,
  input  logic            ev_buf_full,
  input  logic            ev_tmr_ovf,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            can_irq,
  output logic            tmr_irq,
  output logic [NOBJ-1:0] obj_pend
);

  logic [6:0]      ctrl;
  logic [4:0]      gflg;
  logic [NOBJ-1:0] oien;
  logic [2:0]      ostat [NOBJ];
  logic [NOBJ-1:0] opend;
  logic            bit_dly;

  wire owned   = |err_owner;
  wire err_any = ev_form_err | ev_bit_err | ev_stuff_err;
  wire form_g  = ev_form_err & ~owned;

  wire [4:0] gset = {ev_tmr_ovf, ev_buf_full, ev_stuff_err & ~owned,
                     (ev_bit_err & ~owned) | bit_dly, form_g};
  wire [4:0] gclr = (wr_en && wr_addr == AW'(1)) ? wr_data[4:0] : 5'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      oien    <= '0;
      gflg    <= '0;
      bit_dly <= 1'b0;
    end else begin
      if (wr_en && wr_addr == AW'(0)) ctrl <= wr_data[6:0];
      if (wr_en && wr_addr == AW'(2)) oien <= wr_data[NOBJ-1:0];
      gflg    <= gset | (gflg & ~gclr);
      bit_dly <= form_g & tx_active;
    end
  end

  for (genvar k = 0; k < NOBJ; k++) begin : g_obj
    wire [2:0] oset = {err_any & err_owner[k], ev_tx[k], ev_rx[k]};
    wire [2:0] oclr = (wr_en && wr_addr == AW'(4 + k)) ? wr_data[2:0] : 3'b0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ostat[k] <= '0;
      else        ostat[k] <= oset | (ostat[k] & ~oclr);
    end
    assign opend[k] = ctrl[0] & oien[k] & |(ostat[k] & ctrl[6:4]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      can_irq  <= 1'b0;
      tmr_irq  <= 1'b0;
      obj_pend <= '0;
    end else begin
      can_irq  <= ctrl[0] & ((ctrl[1] & |gflg[2:0]) | (ctrl[2] & gflg[3]) | |opend);
      tmr_irq  <= ctrl[3] & gflg[4];
      obj_pend <= opend;
    end
  end

  always_comb begin
    rd_data = '0;
    case (int'(rd_addr))
      0: rd_data[6:0]      = ctrl;
      1: rd_data[4:0]      = gflg;
      2: rd_data[NOBJ-1:0] = oien;
      3: rd_data[NOBJ-1:0] = opend;
      default: begin
        for (int k = 0; k < NOBJ; k++)
          if (int'(rd_addr) == 4 + k) rd_data[2:0] = ostat[k];
      end
    endcase
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |(gflg & ~gclr) |=> ((gflg & $past(gflg & ~gclr)) == $past(gflg & ~gclr)));

  assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_full |=> gflg[3]);

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> !can_irq);

  assert_timer_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> $past(ctrl[3] & gflg[4]));

  assert_pend_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    |obj_pend |-> ((obj_pend & ~$past(oien)) == '0));

  assert_owned_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && owned && !bit_dly) |=> ((gflg[2:0] & ~$past(gflg[2:0])) == 3'b0));

  assert_double_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_form_err && !owned && tx_active) |=> bit_dly ##1 gflg[1]);

endmodule

// File: tb/can_irq_agg_bench.sv
`timescale 1ns/1ps
module can_irq_agg_bench;
  localparam int NOBJ = 4;
  localparam int AW = $clog2(NOBJ + 4);
  localparam int DW = (NOBJ > 7) ? NOBJ : 7;

  logic clk = 0, rst_n = 0;
  logic [NOBJ-1:0] ev_rx = 0, ev_tx = 0, err_owner = 0;
  logic ev_form_err = 0, ev_bit_err = 0, ev_stuff_err = 0;
  logic tx_active = 0, ev_buf_full = 0, ev_tmr_ovf = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [DW-1:0] rd_data;
  logic can_irq, tmr_irq;
  logic [NOBJ-1:0] obj_pend;

  always #2 clk = ~clk;

  can_irq_agg #(.NOBJ(NOBJ)) u_can_irq_agg (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  bit [6:0] m_ctrl;
  bit [4:0] m_g;
  bit [NOBJ-1:0] m_oien;
  bit [2:0] m_o [NOBJ];
  bit m_bd;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [NOBJ-1:0] pend_of();
    bit [NOBJ-1:0] p;
    for (int k = 0; k < NOBJ; k++) p[k] = m_ctrl[0] & m_oien[k] & |(m_o[k] & m_ctrl[6:4]);
    return p;
  endfunction

  function automatic bit [DW-1:0] rd_exp(int a);
    bit [DW-1:0] r = '0;
    if (a == 0) r[6:0] = m_ctrl;
    else if (a == 1) r[4:0] = m_g;
    else if (a == 2) r[NOBJ-1:0] = m_oien;
    else if (a == 3) r[NOBJ-1:0] = pend_of();
    else if (a - 4 < NOBJ) r[2:0] = m_o[a - 4];
    return r;
  endfunction

  task automatic idle_inputs();
    ev_rx = 0; ev_tx = 0; err_owner = 0; ev_form_err = 0; ev_bit_err = 0;
    ev_stuff_err = 0; ev_buf_full = 0; ev_tmr_ovf = 0; wr_en = 0;
  endtask

  task automatic tick();
    bit e_can, e_tmr, own;
    bit [NOBJ-1:0] e_pend;
    bit [4:0] gs, gc;
    @(posedge clk); @(negedge clk);
    e_pend = pend_of();
    e_can = m_ctrl[0] & ((m_ctrl[1] & |m_g[2:0]) | (m_ctrl[2] & m_g[3]) | |e_pend);
    e_tmr = m_ctrl[3] & m_g[4];
    own = |err_owner;
    gs = {ev_tmr_ovf, ev_buf_full, ev_stuff_err & ~own, (ev_bit_err & ~own) | m_bd, ev_form_err & ~own};
    gc = (wr_en && wr_addr == 1) ? wr_data[4:0] : 5'b0;
    m_g = gs | (m_g & ~gc);
    m_bd = ev_form_err & ~own & tx_active;
    for (int k = 0; k < NOBJ; k++) begin
      bit [2:0] os, oc;
      os = {(ev_form_err | ev_bit_err | ev_stuff_err) & err_owner[k], ev_tx[k], ev_rx[k]};
      oc = (wr_en && int'(wr_addr) == 4 + k) ? wr_data[2:0] : 3'b0;
      m_o[k] = os | (m_o[k] & ~oc);
    end
    if (wr_en && wr_addr == 0) m_ctrl = wr_data[6:0];
    if (wr_en && wr_addr == 2) m_oien = wr_data[NOBJ-1:0];
    chk(can_irq === e_can, "R10 can_irq", can_irq, e_can);
    chk(tmr_irq === e_tmr, "R10 tmr_irq", tmr_irq, e_tmr);
    chk(obj_pend === e_pend, "R10 obj_pend", obj_pend, e_pend);
    chk(rd_data === rd_exp(int'(rd_addr)), "R10 rd_data", rd_data, rd_exp(int'(rd_addr)));
    idle_inputs();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d); tick();
  endtask

  task automatic rd_chk(int a, int exp, string tag);
    rd_addr = AW'(a); #1;
    chk(rd_data === DW'(exp), tag, rd_data, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({can_irq, tmr_irq, obj_pend} === '0, "R1 outputs", {can_irq, tmr_irq, obj_pend}, 0);
    for (int a = 0; a < 8; a++) rd_chk(a, 0, "R1 register");
    rst_n = 1;
    tick();

    // R2 sticky and write-one-to-clear
    ev_buf_full = 1; tick();
    tick(); tick();
    rd_chk(1, 5'b01000, "R2 flag holds");
    wr(1, 5'b10111);
    rd_chk(1, 5'b01000, "R2 zero-written bit kept");
    wr(1, 5'b01000);
    rd_chk(1, 0, "R2 cleared");

    // R3 event wins over clear
    ev_buf_full = 1; tick();
    ev_buf_full = 1; wr(1, 5'b01000);
    rd_chk(1, 5'b01000, "R3 event beats clear");
    wr(1, 5'b11111);

    // R4 general error gating
    wr(0, 7'b0000010);
    ev_stuff_err = 1; tick(); tick();
    chk(can_irq === 0, "R4 no irq without global enable", can_irq, 0);
    wr(0, 7'b0000011); tick();
    chk(can_irq === 1, "R4 irq with both enables", can_irq, 1);
    wr(1, 5'b00100); tick();
    chk(can_irq === 0, "R4 irq drops after clear", can_irq, 0);

    // R5 buffer full gating
    wr(0, 7'b0000001);
    ev_buf_full = 1; tick(); tick();
    chk(can_irq === 0, "R5 no irq without buffer enable", can_irq, 0);
    wr(0, 7'b0000101); tick();
    chk(can_irq === 1, "R5 irq with buffer enable", can_irq, 1);
    wr(1, 5'b01000);

    // R6 timer line independent of global enable
    wr(0, 7'b0001000);
    ev_tmr_ovf = 1; tick(); tick();
    chk(tmr_irq === 1, "R6 timer irq", tmr_irq, 1);
    chk(can_irq === 0, "R6 timer not on can line", can_irq, 0);
    wr(1, 5'b10000);

    // R7 and R11 pending until all enabled flags cleared
    wr(0, 7'b0110001); wr(2, 4'b0010);
    ev_rx = 4'b0010; ev_tx = 4'b0010; tick();
    rd_chk(3, 4'b0010, "R7 pending read");
    tick();
    chk(can_irq === 1, "R11 pending drives can_irq", can_irq, 1);
    wr(5, 3'b001);
    rd_chk(3, 4'b0010, "R7 pending held by tx flag");
    wr(5, 3'b010);
    rd_chk(3, 0, "R7 pending released");
    tick();
    chk(obj_pend === 0, "R7 obj_pend low", obj_pend, 0);

    // R8 owned errors stay out of general flags
    tx_active = 1; ev_form_err = 1; err_owner = 4'b0100; tick(); tick();
    rd_chk(1, 0, "R8 no general flag");
    rd_chk(6, 3'b100, "R8 object error flag");
    wr(6, 3'b100);

    // R9 form error in transmit yields bit error one cycle later
    tx_active = 1; ev_form_err = 1; tick();
    rd_chk(1, 5'b00001, "R9 form flag first");
    tick();
    rd_chk(1, 5'b00011, "R9 bit flag follows");
    tx_active = 0;
    wr(1, 5'b11111);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      ev_rx = NOBJ'($urandom_range(0, 15) & (($urandom_range(0, 3) == 0) ? 4'hF : 4'h0));
      ev_tx = NOBJ'($urandom_range(0, 15) & (($urandom_range(0, 3) == 0) ? 4'hF : 4'h0));
      ev_form_err = ($urandom_range(0, 7) == 0);
      ev_bit_err = ($urandom_range(0, 9) == 0);
      ev_stuff_err = ($urandom_range(0, 9) == 0);
      err_owner = ($urandom_range(0, 1) == 0) ? '0 : NOBJ'($urandom_range(0, 15));
      tx_active = $urandom_range(0, 1);
      ev_buf_full = ($urandom_range(0, 11) == 0);
      ev_tmr_ovf = ($urandom_range(0, 11) == 0);
      wr_en = ($urandom_range(0, 2) == 0);
      wr_addr = AW'($urandom_range(0, 7));
      wr_data = DW'($urandom_range(0, 127));
      rd_addr = AW'($urandom_range(0, 7));
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule